// File: doc/BRIEF.md
# VCO Sub-band Lock Seeker

This controller finds a working oscillator setting for a frequency synthesizer that offers three selectable VCOs, each split into eight sub-bands. After a start pulse it writes a setting to the synthesizer's VCO register, waits a programmable settling time, and samples a 3-bit tuning-voltage indicator. When the indicator reports a rail, the block moves one position down or up and tries again. It stops at the first setting that reports lock.

The 24 settings form one linear search space. Position p = (VCO number - 1) * 8 + sub-band, so position 0 is VCO1 sub-band 0 and position 23 is VCO3 sub-band 7. A step across a sub-band boundary lands on the adjacent VCO. The search gives up and raises fail in two cases: it would have to leave the space at either end, or the indicator changes its requested direction, which shows that no setting locks.

The register transport is not part of this block. The block pulses `reg_wr` in the cycle it presents a new `reg_val`, and pulses `ind_rd` in the cycle it takes in `tune_ind`.

The block is built around a five-state machine:
- IDLE waits for start and goes to WRITE when start is seen.
- WRITE presents the new value with `reg_wr` high, loads the settle timer, and goes to SETTLE.
- SETTLE waits until the timer drains, then goes to SAMPLE.
- SAMPLE classifies the indicator. Lock goes to DONE. A legal step goes back to WRITE. A step off either end, or a step against the earlier direction, goes to DONE with fail set.
- DONE holds its results and goes to WRITE on a new start.

Top module: `vbs_seeker`

## Requirements
- R1: After reset `done`, `locked`, `fail`, `reg_wr` and `ind_rd` are 0, and `reg_val` is 8'h44 (VCO1, sub-band 0, lock-detect enabled, divider code 00).
- R2: `reg_val` holds the VCO select in bits 7:6 (01, 10 and 11 mean VCO1, VCO2 and VCO3), the sub-band in bits 5:3, the lock-detect enable in bit 2 (always 1), and in bits 1:0 the `div_sel` value captured at start (00, 01, 10 and 11 mean divide by 4, 8, 16 and 32). The VCO select field is never 00. A starting guess with VCO select 00 is taken as VCO1.
- R3: Every `ind_rd` pulse comes exactly `settle_cycles` + 2 clock cycles after the `reg_wr` pulse before it. `settle_cycles` is captured at start.
- R4: An indicator from 001 to 110 at a sample ends the search with `done` = 1, `locked` = 1 and `fail` = 0, and no further write follows.
- R5: An indicator of 000 makes the next write one position lower, and 111 makes it one position higher. Position p = (VCO - 1) * 8 + sub-band, so a step from sub-band 7 upward or from sub-band 0 downward changes the VCO.
- R6: An indicator of 000 at position 0, or 111 at position 23, ends the search with `done` = 1 and `fail` = 1, with no further write. `reg_val` keeps the last value written.
- R7: A request for the opposite direction to one already taken in the same search ends it with `done` = 1 and `fail` = 1.
- R8: While `done` = 1 and no start arrives, `reg_val`, `locked` and `fail` stay unchanged. A start in DONE begins a new search.
- R9: A start pulse while a search is running is ignored and does not change the result.
- R10: `locked` and `fail` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a search when idle or done |
| init_vco | input | VCO_W (2) | Starting VCO select |
| init_sub | input | SUB_W (3) | Starting sub-band |
| div_sel | input | 2 | Divider code copied into reg_val[1:0] |
| settle_cycles | input | SETTLE_W (8) | Settle wait per step |
| tune_ind | input | 3 | Tuning-voltage indicator |
| reg_wr | output | 1 | One-cycle strobe with a new reg_val |
| ind_rd | output | 1 | One-cycle strobe when tune_ind is taken |
| reg_val | output | VCO_W+SUB_W+3 (8) | VCO register value |
| done | output | 1 | Search finished, held until the next start |
| locked | output | 1 | Search ended on a locking setting |
| fail | output | 1 | Search ended without lock |

## Verification
The assertions rely on two conditions at the inputs:
- `tune_ind` is a settled function of the last written `reg_val` when `ind_rd` samples it.
- `start` may arrive at any time but only matters in IDLE or DONE.

The bench keeps to both. Its indicator model is a combinational function of `reg_val`, which cannot change between a write and its sample. Its start pulses last one cycle and are driven on the falling edge, including the one deliberately fired in the middle of a search.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WRITE,
        S_SETTLE,
        S_SAMPLE,
        S_DONE
    } seek_state_t;

    localparam int          DIV_W     = 2;
    localparam logic [2:0]  IND_LOW   = 3'b000;
    localparam logic [2:0]  IND_HIGH  = 3'b111;

endpackage

// File: rtl/vbs_index_map.sv
// Maps between the linear search position and the VCO / sub-band fields.
module vbs_index_map #(
    parameter int VCO_W   = 2,
    parameter int SUB_W   = 3,
    parameter int NUM_VCO = 3,
    parameter int IDX_W   = 5
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [VCO_W-1:0] guess_vco,
    input  logic [SUB_W-1:0] guess_sub,
    output logic [VCO_W-1:0] vco_sel,
    output logic [SUB_W-1:0] sub_sel,
    output logic [IDX_W-1:0] guess_idx
);
    localparam int HI_W = IDX_W - SUB_W;
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'((NUM_VCO << SUB_W) - 1);

    logic [VCO_W-1:0] vco_ofs;
    logic [IDX_W-1:0] raw_idx;

    // VCO select is one above the upper position bits: never 00.
    assign vco_sel = VCO_W'(idx[IDX_W-1:SUB_W]) + VCO_W'(1);
    assign sub_sel = idx[SUB_W-1:0];

    always_comb begin
        vco_ofs   = (guess_vco == '0) ? '0 : guess_vco - VCO_W'(1);
        raw_idx   = {HI_W'(vco_ofs), guess_sub};
        guess_idx = (raw_idx > TOP_IDX) ? TOP_IDX : raw_idx;
    end

endmodule

// File: rtl/vbs_settle_timer.sv
// Down-counter that sets the settle wait after each register write.
module vbs_settle_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);

    // R3: a running timer drains one count per cycle
    p_timer_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt != '0) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/vbs_seeker.sv
module vbs_seeker
    import vbs_pkg::*;
#(
    parameter int VCO_W    = 2,
    parameter int SUB_W    = 3,
    parameter int NUM_VCO  = 3,
    parameter int SETTLE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [VCO_W-1:0]          init_vco,
    input  logic [SUB_W-1:0]          init_sub,
    input  logic [1:0]                div_sel,
    input  logic [SETTLE_W-1:0]       settle_cycles,
    input  logic [2:0]                tune_ind,
    output logic                      reg_wr,
    output logic                      ind_rd,
    output logic [VCO_W+SUB_W+2:0]    reg_val,
    output logic                      done,
    output logic                      locked,
    output logic                      fail
);
    localparam int NUM_POS = NUM_VCO << SUB_W;
    localparam int IDX_W   = $clog2(NUM_POS);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_POS - 1);

    seek_state_t st, st_nx;

    logic [IDX_W-1:0]    idx_q, guess_idx;
    logic [DIV_W-1:0]    div_q;
    logic [SETTLE_W-1:0] settle_q;
    logic                seen_up, seen_dn, locked_q, fail_q;
    logic [VCO_W-1:0]    vco_sel;
    logic [SUB_W-1:0]    sub_sel;
    logic                tmr_expired;
    logic                go, want_dn, want_up, dead_dn, dead_up;

    vbs_index_map #(
        .VCO_W(VCO_W), .SUB_W(SUB_W), .NUM_VCO(NUM_VCO), .IDX_W(IDX_W)
    ) u_map (
        .idx       (idx_q),
        .guess_vco (init_vco),
        .guess_sub (init_sub),
        .vco_sel   (vco_sel),
        .sub_sel   (sub_sel),
        .guess_idx (guess_idx)
    );

    vbs_settle_timer #(.W(SETTLE_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st == S_WRITE),
        .load_val (settle_q),
        .run      (st == S_SETTLE),
        .expired  (tmr_expired)
    );

    assign go      = start && (st == S_IDLE || st == S_DONE);
    assign want_dn = (tune_ind == IND_LOW);
    assign want_up = (tune_ind == IND_HIGH);
    assign dead_dn = want_dn && (idx_q == '0 || seen_up);
    assign dead_up = want_up && (idx_q == TOP_IDX || seen_dn);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // Transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:   if (go) st_nx = S_WRITE;
            S_WRITE:  st_nx = S_SETTLE;
            S_SETTLE: if (tmr_expired) st_nx = S_SAMPLE;
            S_SAMPLE: begin
                if (want_dn)      st_nx = dead_dn ? S_DONE : S_WRITE;
                else if (want_up) st_nx = dead_up ? S_DONE : S_WRITE;
                else              st_nx = S_DONE;
            end
            S_DONE:   if (go) st_nx = S_WRITE;
            default:  st_nx = S_IDLE;
        endcase
    end

    // Search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q    <= '0;
            div_q    <= '0;
            settle_q <= '0;
            seen_up  <= 1'b0;
            seen_dn  <= 1'b0;
            locked_q <= 1'b0;
            fail_q   <= 1'b0;
        end else if (go) begin
            idx_q    <= guess_idx;
            div_q    <= div_sel;
            settle_q <= settle_cycles;
            seen_up  <= 1'b0;
            seen_dn  <= 1'b0;
            locked_q <= 1'b0;
            fail_q   <= 1'b0;
        end else if (st == S_SAMPLE) begin
            if (want_dn) begin
                if (dead_dn) fail_q <= 1'b1;
                else begin
                    idx_q   <= idx_q - IDX_W'(1);
                    seen_dn <= 1'b1;
                end
            end else if (want_up) begin
                if (dead_up) fail_q <= 1'b1;
                else begin
                    idx_q   <= idx_q + IDX_W'(1);
                    seen_up <= 1'b1;
                end
            end else begin
                locked_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        reg_wr  = (st == S_WRITE);
        ind_rd  = (st == S_SAMPLE);
        done    = (st == S_DONE);
        locked  = locked_q;
        fail    = fail_q;
        reg_val = {vco_sel, sub_sel, 1'b1, div_q};
    end

    // ---------------- checks ----------------
    logic [SETTLE_W:0] since_wr;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                since_wr <= '1;
        else if (reg_wr)           since_wr <= '0;
        else if (since_wr != '1)   since_wr <= since_wr + (SETTLE_W+1)'(1);
    end

    p_vco_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_val[VCO_W+SUB_W+2:SUB_W+3] != '0) && reg_val[2]);

    p_settle_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ind_rd |-> (since_wr == {1'b0, settle_q} + (SETTLE_W+1)'(1)));

    p_lock_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_rd && !want_dn && !want_up) |=> (done && locked && !reg_wr));

    p_step_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ind_rd && st_nx == S_WRITE) |=>
            (idx_q == $past(idx_q) + IDX_W'(1) || idx_q == $past(idx_q) - IDX_W'(1)));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(reg_val) && $stable(locked) && $stable(fail)));

    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && fail));

endmodule

// File: tb/vbs_seeker_test.sv
module vbs_seeker_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] init_vco = 2'b01;
    logic [2:0] init_sub = 3'd0;
    logic [1:0] div_sel = 2'b00;
    logic [7:0] settle_cycles = 8'd0;
    logic [2:0] tune_ind;
    logic       reg_wr, ind_rd, done, locked, fail;
    logic [7:0] reg_val;

    int n_checks = 0;
    int n_fail   = 0;

    // indicator model: 0 target lock, 1 always high, 2 always low, 3 gap above k
    int mode   = 0;
    int target = 0;
    int pos;

    always #5 clk = ~clk;

    vbs_seeker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .init_vco(init_vco),
        .init_sub(init_sub), .div_sel(div_sel), .settle_cycles(settle_cycles),
        .tune_ind(tune_ind), .reg_wr(reg_wr), .ind_rd(ind_rd),
        .reg_val(reg_val), .done(done), .locked(locked), .fail(fail)
    );

    always_comb begin
        pos = (int'(reg_val[7:6]) - 1) * 8 + int'(reg_val[5:3]);
        case (mode)
            1:       tune_ind = 3'b111;
            2:       tune_ind = 3'b000;
            3:       tune_ind = (pos <= target) ? 3'b111 : 3'b000;
            default: tune_ind = (pos < target) ? 3'b111 :
                                (pos > target) ? 3'b000 : 3'b011;
        endcase
    end

    // write count and write-to-sample gap, sampled away from the active edge
    int cyc = 0, wr_total = 0, wr_at = 0, last_gap = 0, gap_bad = 0, gap_exp = 0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (reg_wr) begin
            wr_total = wr_total + 1;
            wr_at = cyc;
        end
        if (ind_rd) begin
            last_gap = cyc - wr_at;
            if (last_gap != gap_exp) gap_bad = gap_bad + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        if (!done) check("watchdog done", 0, 1);
    endtask

    task automatic run(input logic [1:0] v, input logic [2:0] s, input logic [1:0] d,
                       input int settle, input int m, input int tgt, output int writes);
        int base;
        init_vco = v; init_sub = s; div_sel = d;
        settle_cycles = 8'(settle); mode = m; target = tgt;
        gap_exp = settle + 2;
        base = wr_total;
        pulse_start();
        wait_done();
        writes = wr_total - base;
    endtask

    task automatic t_reset();
        check("R1 reg_val", int'(reg_val), 'h44);
        check("R1 done", int'(done), 0);
        check("R1 locked", int'(locked), 0);
        check("R1 fail", int'(fail), 0);
        check("R1 strobes", int'(reg_wr | ind_rd), 0);
    endtask

    task automatic t_lock_first();
        int w;
        run(2'b10, 3'd3, 2'b10, 5, 0, 11, w);
        check("R4 locked", int'(locked), 1);
        check("R4 fail", int'(fail), 0);
        check("R4 writes", w, 1);
        check("R2 reg_val fields", int'(reg_val), 'h9E);
        check("R3 settle gap", last_gap, 7);
    endtask

    task automatic t_step_up();
        int w;
        run(2'b01, 3'd6, 2'b00, 0, 0, 9, w);
        check("R5 up writes", w, 4);
        check("R5 up reg_val", int'(reg_val), 'h8C);
        check("R5 up locked", int'(locked), 1);
        check("R3 zero settle gap", last_gap, 2);
    endtask

    task automatic t_step_down();
        int w;
        run(2'b11, 3'd1, 2'b01, 2, 0, 14, w);
        check("R5 down writes", w, 4);
        check("R5 down reg_val", int'(reg_val), 'hB5);
        check("R5 down locked", int'(locked), 1);
    endtask

    task automatic t_top_edge();
        int w;
        run(2'b11, 3'd7, 2'b11, 3, 1, 0, w);
        check("R6 top writes", w, 1);
        check("R6 top fail", int'(fail), 1);
        check("R6 top locked", int'(locked), 0);
        check("R6 top reg_val", int'(reg_val), 'hFF);
        check("R3 settle gap 3", last_gap, 5);
    endtask

    task automatic t_bottom_edge();
        int w;
        run(2'b01, 3'd1, 2'b00, 1, 2, 0, w);
        check("R6 bottom writes", w, 2);
        check("R6 bottom fail", int'(fail), 1);
        check("R6 bottom reg_val", int'(reg_val), 'h44);
    endtask

    task automatic t_reversal();
        int w;
        run(2'b01, 3'd4, 2'b00, 1, 3, 5, w);
        check("R7 writes", w, 3);
        check("R7 fail", int'(fail), 1);
        check("R7 reg_val", int'(reg_val), 'h74);
        check("R10 exclusive", int'(locked & fail), 0);
    endtask

    task automatic t_vco_zero();
        int w;
        run(2'b00, 3'd2, 2'b00, 0, 0, 2, w);
        check("R2 vco00 as VCO1", int'(reg_val), 'h54);
        check("R2 vco00 writes", w, 1);
    endtask

    task automatic t_hold();
        logic [7:0] kept;
        int base;
        kept = reg_val;
        base = wr_total;
        mode = 1;
        repeat (20) @(negedge clk);
        check("R8 reg_val held", int'(reg_val), int'(kept));
        check("R8 done held", int'(done), 1);
        check("R4 no write after lock", wr_total - base, 0);
    endtask

    task automatic t_busy_start();
        int base;
        init_vco = 2'b01; init_sub = 3'd0; div_sel = 2'b00;
        settle_cycles = 8'd10; mode = 0; target = 3; gap_exp = 12;
        base = wr_total;
        pulse_start();
        repeat (3) @(negedge clk);
        init_vco = 2'b11; init_sub = 3'd7;
        pulse_start();
        wait_done();
        check("R9 writes", wr_total - base, 4);
        check("R9 reg_val", int'(reg_val), 'h5C);
        check("R9 locked", int'(locked), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_lock_first();
        t_hold();
        t_step_up();
        t_step_down();
        t_top_edge();
        t_bottom_edge();
        t_reversal();
        t_vco_zero();
        t_busy_start();
        check("R3 all settle gaps", gap_bad, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule